// File: doc/BRIEF.md
# Per-Core Power Transition Controller

This block steers a group of power-gated cores of one kind toward a wanted on/off pattern. On each evaluation strobe it takes a snapshot of five core bitmaps: the cores software wants powered, the cores that are busy with work, the cores that physically exist, the cores whose supply is up, and the cores whose supply is still switching. From that snapshot it issues a power-on request mask and a power-off request mask.

Each request mask leaves the block as a lower and an upper half. Every half carries its own write strobe, and that strobe is raised only when the half holds at least one set bit. An upper half belongs one word step (four bytes) above its lower half. The same evaluation also updates a settled flag and a mask of cores that the scheduler may use. A per-kind keep-on input makes every existing core a target, whatever the wanted mask says.

Cores that are still switching are left alone until they settle. Busy cores are always treated as wanted. A wanted core that does not exist never gets a request. The surrounding power policy repeats evaluations until the settled flag comes back high.

Top module: `pwr_gate_steer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every request half, every write strobe, `done_o`, `avail_o` and `result_vld_o` read zero.
- R2: The target mask is `desired_i | in_use_i`, so a busy core is never in the power-off mask even when `desired_i` has its bit clear.
- R3: The power-on mask is target AND present AND NOT ready AND NOT switching.
- R4: The power-off mask is NOT target AND present AND ready AND NOT switching. A single evaluation can raise power-on and power-off bits in the same cycle, and the two masks never overlap.
- R5: A core whose `trans_i` bit is set appears in neither request mask.
- R6: `done_o` is 1 exactly when the target mask equals `ready_i` and `trans_i` is all zero. When that holds, no request strobe is raised.
- R7: `avail_o` equals `ready_i & desired_i`, using the wanted mask before busy cores are merged in and before keep-on is applied.
- R8: Bits [HALF_W-1:0] of a request mask appear on the `_lo_o` port and the remaining bits on the `_hi_o` port. A half's write strobe is 1 only when that half is nonzero.
- R9: With `keep_all_on_i` = 1 the target mask is `present_i`, and `desired_i` and `in_use_i` play no part in the requests or in `done_o`.
- R10: A wanted core whose `present_i` bit is 0 gets no request, and because it can never be ready, `done_o` stays 0.
- R11: Outputs change one clock after a cycle with `eval_i` = 1. The request halves and their strobes last one cycle. `done_o` and `avail_o` hold until the next evaluation, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Sample the core bitmaps and evaluate this cycle |
| keep_all_on_i | input | 1 | Make every present core a power target |
| desired_i | input | 2*HALF_W | Cores software wants powered |
| in_use_i | input | 2*HALF_W | Cores running work |
| present_i | input | 2*HALF_W | Cores that exist |
| ready_i | input | 2*HALF_W | Cores whose supply is up |
| trans_i | input | 2*HALF_W | Cores whose supply is switching |
| on_lo_o | output | HALF_W | Power-on request, lower half |
| on_hi_o | output | HALF_W | Power-on request, upper half |
| on_lo_wr_o | output | 1 | Write strobe for the lower power-on half |
| on_hi_wr_o | output | 1 | Write strobe for the upper power-on half |
| off_lo_o | output | HALF_W | Power-off request, lower half |
| off_hi_o | output | HALF_W | Power-off request, upper half |
| off_lo_wr_o | output | 1 | Write strobe for the lower power-off half |
| off_hi_wr_o | output | 1 | Write strobe for the upper power-off half |
| done_o | output | 1 | Target pattern reached with nothing switching |
| avail_o | output | 2*HALF_W | Cores the scheduler may use |
| result_vld_o | output | 1 | Outputs belong to the evaluation of the previous cycle |

## Verification
Power-on and power-off requests can come out of the same evaluation. So can the forced keep-alive of a busy core, even while another core whose wanted bit is cleared is being shut down. Vectors with alternating ready and wanted patterns across both halves provoke all four strobes at once. Vectors with busy bits outside the wanted mask check that those bits stay out of the power-off mask. Each result is judged against masks that the bench builds from the requirement formulas, sampled on the falling edge after the evaluating edge.

// File: rtl/pwr_steer_pkg.sv
package pwr_steer_pkg;

    localparam int unsigned HALF_DEF = 32;

    // Which request a splitter instance serves.
    typedef enum logic {
        KIND_ON  = 1'b0,
        KIND_OFF = 1'b1
    } req_kind_t;

    // Per-half write strobes of one request mask.
    typedef struct packed {
        logic hi;
        logic lo;
    } wr_pair_t;

    // Byte step between the lower and upper half of a request word.
    localparam int unsigned HALF_STEP = 4;

endpackage

// File: rtl/pwr_steer_plan.sv
module pwr_steer_plan #(
    parameter int unsigned N_CORES = 64
) (
    input  logic               keep_all_on_i,
    input  logic [N_CORES-1:0] desired_i,
    input  logic [N_CORES-1:0] in_use_i,
    input  logic [N_CORES-1:0] present_i,
    input  logic [N_CORES-1:0] ready_i,
    input  logic [N_CORES-1:0] trans_i,
    output logic [N_CORES-1:0] up_o,
    output logic [N_CORES-1:0] down_o,
    output logic [N_CORES-1:0] usable_o,
    output logic               settled_o
);

    logic [N_CORES-1:0] target;
    logic [N_CORES-1:0] free_cores;

    always_comb begin
        // Busy cores are always targets; keep-on overrides both.
        target     = keep_all_on_i ? present_i : (desired_i | in_use_i);
        free_cores = present_i & ~trans_i;
        settled_o  = (target == ready_i) && (trans_i == '0);
        usable_o   = ready_i & desired_i;
        if (settled_o) begin
            up_o   = '0;
            down_o = '0;
        end else begin
            up_o   = target  & free_cores & ~ready_i;
            down_o = ~target & free_cores &  ready_i;
        end
    end

endmodule

// File: rtl/pwr_steer_split.sv
module pwr_steer_split
    import pwr_steer_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_DEF
) (
    input  logic [2*HALF_W-1:0] mask_i,
    output logic [HALF_W-1:0]   lo_o,
    output logic [HALF_W-1:0]   hi_o,
    output wr_pair_t            wr_o
);

    localparam int unsigned N_HALVES = 2;

    logic [HALF_W-1:0] part [N_HALVES];
    logic [N_HALVES-1:0] nz;

    for (genvar h = 0; h < N_HALVES; h++) begin : g_half
        assign part[h] = mask_i[h*HALF_W +: HALF_W];
        assign nz[h]   = |part[h];
    end

    assign lo_o    = part[0];
    assign hi_o    = part[1];
    assign wr_o.lo = nz[0];
    assign wr_o.hi = nz[1];

endmodule

// File: rtl/pwr_gate_steer.sv
module pwr_gate_steer
    import pwr_steer_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                eval_i,
    input  logic                keep_all_on_i,
    input  logic [2*HALF_W-1:0] desired_i,
    input  logic [2*HALF_W-1:0] in_use_i,
    input  logic [2*HALF_W-1:0] present_i,
    input  logic [2*HALF_W-1:0] ready_i,
    input  logic [2*HALF_W-1:0] trans_i,
    output logic [HALF_W-1:0]   on_lo_o,
    output logic [HALF_W-1:0]   on_hi_o,
    output logic                on_lo_wr_o,
    output logic                on_hi_wr_o,
    output logic [HALF_W-1:0]   off_lo_o,
    output logic [HALF_W-1:0]   off_hi_o,
    output logic                off_lo_wr_o,
    output logic                off_hi_wr_o,
    output logic                done_o,
    output logic [2*HALF_W-1:0] avail_o,
    output logic                result_vld_o
);

    localparam int unsigned N_CORES = 2 * HALF_W;
    localparam int unsigned N_KINDS = 2;

    logic [N_CORES-1:0] up_c, down_c, usable_c;
    logic               settled_c;

    pwr_steer_plan #(.N_CORES(N_CORES)) u_plan (
        .keep_all_on_i (keep_all_on_i),
        .desired_i     (desired_i),
        .in_use_i      (in_use_i),
        .present_i     (present_i),
        .ready_i       (ready_i),
        .trans_i       (trans_i),
        .up_o          (up_c),
        .down_o        (down_c),
        .usable_o      (usable_c),
        .settled_o     (settled_c)
    );

    logic [HALF_W-1:0] lo_c [N_KINDS];
    logic [HALF_W-1:0] hi_c [N_KINDS];
    wr_pair_t          wr_c [N_KINDS];
    logic [HALF_W-1:0] lo_q [N_KINDS];
    logic [HALF_W-1:0] hi_q [N_KINDS];
    wr_pair_t          wr_q [N_KINDS];

    for (genvar g = 0; g < N_KINDS; g++) begin : g_kind
        localparam req_kind_t KIND = (g == 0) ? KIND_ON : KIND_OFF;

        pwr_steer_split #(.HALF_W(HALF_W)) u_split (
            .mask_i ((KIND == KIND_ON) ? up_c : down_c),
            .lo_o   (lo_c[g]),
            .hi_o   (hi_c[g]),
            .wr_o   (wr_c[g])
        );

        // Requests are one-cycle pulses tied to an evaluation.
        always_ff @(posedge clk) begin
            if (rst || !eval_i) begin
                lo_q[g] <= '0;
                hi_q[g] <= '0;
                wr_q[g] <= '0;
            end else begin
                lo_q[g] <= lo_c[g];
                hi_q[g] <= hi_c[g];
                wr_q[g] <= wr_c[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o       <= 1'b0;
            avail_o      <= '0;
            result_vld_o <= 1'b0;
        end else begin
            result_vld_o <= eval_i;
            if (eval_i) begin
                done_o  <= settled_c;
                avail_o <= usable_c;
            end
        end
    end

    assign on_lo_o     = lo_q[0];
    assign on_hi_o     = hi_q[0];
    assign on_lo_wr_o  = wr_q[0].lo;
    assign on_hi_wr_o  = wr_q[0].hi;
    assign off_lo_o    = lo_q[1];
    assign off_hi_o    = hi_q[1];
    assign off_lo_wr_o = wr_q[1].lo;
    assign off_hi_wr_o = wr_q[1].hi;

    logic [N_CORES-1:0] on_all, off_all;
    logic               any_wr;
    assign on_all  = {on_hi_o, on_lo_o};
    assign off_all = {off_hi_o, off_lo_o};
    assign any_wr  = on_lo_wr_o | on_hi_wr_o | off_lo_wr_o | off_hi_wr_o;

    assert_inuse_kept_R2: assert property (@(posedge clk) disable iff (rst)
        result_vld_o |-> ((off_all & $past(in_use_i)) == '0));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        (on_all & off_all) == '0);

    assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        result_vld_o |-> (((on_all | off_all) & $past(trans_i)) == '0));

    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (result_vld_o && done_o) |-> !any_wr);

    assert_wr_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        (on_lo_wr_o |-> on_lo_o != '0) and (off_hi_wr_o |-> off_hi_o != '0));

    assert_absent_R10: assert property (@(posedge clk) disable iff (rst)
        result_vld_o |-> (((on_all | off_all) & ~$past(present_i)) == '0));

    assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        any_wr |-> $past(eval_i));

endmodule

// File: tb/tb_pwr_gate_steer.sv
module tb_pwr_gate_steer;

    localparam int HW = 32;
    localparam int NC = 2 * HW;

    typedef struct packed {
        logic [NC-1:0] des;
        logic [NC-1:0] busy;
        logic [NC-1:0] pres;
        logic [NC-1:0] rdy;
        logic [NC-1:0] mov;
        logic          keep;
        logic          exp_done;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{64'h0F, 64'h0, 64'hFF, 64'h0, 64'h0, 1'b0, 1'b0},                              // R3 plain power-up
        '{64'h0F, 64'h0, 64'hFF, 64'h0F, 64'h0, 1'b0, 1'b1},                             // R6 settled
        '{64'h03, 64'h04, 64'hFF, 64'h0F, 64'h0, 1'b0, 1'b0},                            // R2 busy core kept
        '{64'h00, 64'h0, 64'hFF, 64'h0F, 64'h03, 1'b0, 1'b0},                            // R5 frozen cores
        '{64'hFFFF_0000_0000_0000, 64'h0, {NC{1'b1}}, 64'h0, 64'h0, 1'b0, 1'b0},          // R8 upper half only
        '{64'h1_0000_0001, 64'h0, 64'hFFFF_FFFF, 64'h1, 64'h0, 1'b0, 1'b0},               // R10 absent core
        '{64'h00, 64'h0F, 64'hF0, 64'h30, 64'h0, 1'b1, 1'b0},                            // R9 keep-on
        '{64'h00, 64'h0, 64'hF0, 64'hF0, 64'h0, 1'b1, 1'b1},                             // R9 keep-on settled
        '{64'hAAAA_AAAA_5555_5555, 64'h0, {NC{1'b1}}, 64'h5555_5555_AAAA_AAAA, 64'h0, 1'b0, 1'b0}, // R4 up and down
        '{64'h00, 64'h0, 64'hFF, 64'h0, 64'h01, 1'b0, 1'b0}                              // R6 only switching
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic eval_i = 1'b0;
    logic keep_all_on_i = 1'b0;
    logic [NC-1:0] desired_i = '0, in_use_i = '0, present_i = '0, ready_i = '0, trans_i = '0;
    logic [HW-1:0] on_lo_o, on_hi_o, off_lo_o, off_hi_o;
    logic on_lo_wr_o, on_hi_wr_o, off_lo_wr_o, off_hi_wr_o, done_o, result_vld_o;
    logic [NC-1:0] avail_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pwr_gate_steer #(.HALF_W(HW)) dut (
        .clk(clk), .rst(rst), .eval_i(eval_i), .keep_all_on_i(keep_all_on_i),
        .desired_i(desired_i), .in_use_i(in_use_i), .present_i(present_i),
        .ready_i(ready_i), .trans_i(trans_i),
        .on_lo_o(on_lo_o), .on_hi_o(on_hi_o), .on_lo_wr_o(on_lo_wr_o), .on_hi_wr_o(on_hi_wr_o),
        .off_lo_o(off_lo_o), .off_hi_o(off_hi_o), .off_lo_wr_o(off_lo_wr_o), .off_hi_wr_o(off_hi_wr_o),
        .done_o(done_o), .avail_o(avail_o), .result_vld_o(result_vld_o)
    );

    task automatic chk(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        desired_i = v.des; in_use_i = v.busy; present_i = v.pres;
        ready_i = v.rdy; trans_i = v.mov; keep_all_on_i = v.keep;
        eval_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        eval_i = 1'b0;
    endtask

    task automatic judge(input vec_t v, input int idx);
        logic [NC-1:0] tgt, up, dn;
        logic settled;
        tgt = v.keep ? v.pres : (v.des | v.busy);
        settled = (tgt == v.rdy) && (v.mov == '0);
        up = settled ? '0 : (tgt & v.pres & ~v.rdy & ~v.mov);
        dn = settled ? '0 : (~tgt & v.pres & v.rdy & ~v.mov);
        if (settled != v.exp_done) $display("table note: vector %0d done column differs", idx);
        chk("R3 on mask", {on_hi_o, on_lo_o}, up);
        chk("R4 off mask", {off_hi_o, off_lo_o}, dn);
        chk("R8 on strobes", {62'd0, on_hi_wr_o, on_lo_wr_o}, {62'd0, |up[NC-1:HW], |up[HW-1:0]});
        chk("R8 off strobes", {62'd0, off_hi_wr_o, off_lo_wr_o}, {62'd0, |dn[NC-1:HW], |dn[HW-1:0]});
        chk("R6 done", {63'd0, done_o}, {63'd0, v.exp_done});
        chk("R7 avail", avail_o, v.rdy & v.des);
        chk("R11 valid", {63'd0, result_vld_o}, 64'd1);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, with eval requested during reset
        eval_i = 1'b1; desired_i = 64'hFF; present_i = 64'hFF;
        @(negedge clk);
        chk("R1 requests", {on_hi_o, on_lo_o, off_hi_o, off_lo_o} == '0 ? 64'd0 : 64'd1, 64'd0);
        chk("R1 flags", {58'd0, on_lo_wr_o, on_hi_wr_o, off_lo_wr_o, off_hi_wr_o, done_o, result_vld_o}, 64'd0);
        chk("R1 avail", avail_o, 64'd0);
        eval_i = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {62'd0, done_o, result_vld_o}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            judge(VECS[i], i);
        end

        // R11: no new evaluation -> strobes drop, done/avail hold despite input change
        apply(VECS[0]);
        desired_i = '0; ready_i = 64'h0F; present_i = 64'hFF;
        @(negedge clk);
        chk("R11 strobes drop", {on_hi_o, on_lo_o}, 64'd0);
        chk("R11 strobe flags", {60'd0, on_lo_wr_o, on_hi_wr_o, off_lo_wr_o, off_hi_wr_o}, 64'd0);
        chk("R11 avail held", avail_o, 64'd0);
        chk("R11 valid drops", {63'd0, result_vld_o}, 64'd0);

        // R2: busy core outside wanted mask stays on; wanted-cleared idle core goes off
        apply('{64'h00, 64'h8000_0000_0000_0001, {NC{1'b1}}, 64'h8000_0000_0000_0003, 64'h0, 1'b0, 1'b0});
        chk("R2 busy kept", {off_hi_o, off_lo_o}, 64'h2);
        chk("R2 avail pre-merge", avail_o, 64'd0);

        // R10 with keep-on: absent core never targeted, done reached
        apply('{64'hF00, 64'h0, 64'h0F, 64'h0F, 64'h0, 1'b1, 1'b1});
        chk("R9 done ignores desired", {63'd0, done_o}, 64'd1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule